// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block decides, at instruction boundaries, whether a pending hardware interrupt is taken. The pending priority comes from a 3-bit encoded level input. It can also come from a bank of individual request lines, which a built-in priority encoder turns into a level. When both sources are active, the higher of the two is used. The current 3-bit interrupt mask from the status register is compared against that level. Level 7 cannot be masked and is taken once per rising occurrence.

When an interrupt is taken, the block raises a one-cycle take pulse and a force-supervisor pulse. It also presents the accepted level as the new mask to load into the status register. It then waits for the acknowledge cycle to finish. The acknowledge outcome selects the vector number:
- an automatic vector (24 plus the level),
- an externally supplied 8-bit vector,
- the spurious vector 24 when no device answered.

The block presents the vector number together with its byte address in the vector table, which is the number times four. Fetching the vector from memory is left to the surrounding logic.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, take, force_super and vec_valid are 0 and new_mask is 0.
- R2: The effective level L (below 7) is accepted when sample_en is 1, no acceptance is awaiting acknowledge, and L > cur_mask. Acceptance shows as take = 1 for exactly one cycle, in the cycle after the sampling edge. Otherwise take stays 0.
- R3: Level 0 is never accepted, whatever the mask.
- R4: Level 7 is accepted at a sample regardless of cur_mask, but only once while the level stays at 7. It is accepted again only after the effective level has been below 7 for at least one clock edge.
- R5: In the take cycle force_super is 1, and new_mask equals the accepted level. new_mask holds that value until the next acceptance.
- R6: After an acceptance, sample_en has no effect until ack_done is seen. No second take occurs before the acknowledge.
- R7: On ack_done with ack_ext = 0 and ack_none = 0, the vector is the autovector 24 + L. The vector outputs appear with vec_valid = 1 for one cycle after the acknowledge edge, and vec_addr = 4 × vec_num.
- R8: On ack_done with ack_ext = 1 and ack_none = 0, vec_num equals ext_vector and vec_addr = 4 × ext_vector.
- R9: On ack_done with ack_none = 1, vec_num is 24 and vec_addr is 96, even when ack_ext is also 1.
- R10: Request line i (bit i of irq_lines) stands for level i+1, and the highest active line wins. The effective level is the larger of the encoded lines and irq_code.
- R11: ack_done while no acceptance is awaiting acknowledge has no effect: vec_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_LINES | Individual request lines, bit i is level i+1 |
| irq_code | input | 3 | Encoded pending level, 0 means none |
| cur_mask | input | 3 | Current interrupt mask from the status register |
| sample_en | input | 1 | Instruction-boundary strobe |
| ack_done | input | 1 | Acknowledge cycle has finished |
| ack_ext | input | 1 | Device supplied its own vector number |
| ack_none | input | 1 | No device answered, use the spurious vector |
| ext_vector | input | 8 | Vector number supplied by the device |
| take | output | 1 | One-cycle pulse when an interrupt is accepted |
| new_mask | output | 3 | Mask value to load, equal to the accepted level |
| force_super | output | 1 | One-cycle pulse forcing supervisor mode |
| vec_valid | output | 1 | One-cycle pulse when the vector outputs are valid |
| vec_num | output | 8 | Selected vector number |
| vec_addr | output | 10 | Byte address of the vector |

## Verification
The assertions check several rules on every cycle:
- an acceptance never repeats back to back;
- a taken level is never 0 and always exceeds the previous mask unless it is 7;
- the vector address is always four times the number;
- the spurious and external outcomes select the vector that the acknowledge asked for.

Only the bench scenarios can show the rest:
- a steady level 7 fires once and re-arms after a dip;
- sampling is ignored while an acknowledge is awaited;
- a stray acknowledge produces nothing;
- the request-line encoder picks the highest line.

Random mixes of levels, masks and acknowledge kinds are checked against a model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int ADDR_W = VEC_W + 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam lvl_t NMI_LVL  = '1;
    localparam vec_t SPUR_VEC = vec_t'(24);

    typedef struct packed {
        logic take;
        logic busy;
        logic armed;
        lvl_t lvl;
    } acc_st_t;

    typedef struct packed {
        logic              valid;
        vec_t              num;
        logic [ADDR_W-1:0] addr;
    } vec_st_t;

    function automatic vec_t auto_vec(lvl_t l);
        return SPUR_VEC + vec_t'(l);
    endfunction
endpackage

// File: rtl/irq_line_enc.sv
module irq_line_enc
    import irq_pkg::*;
#(
    parameter int N_LINES = 7
) (
    input  logic [N_LINES-1:0] lines_i,
    output lvl_t               level_o
);
    always_comb begin
        level_o = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (lines_i[i]) level_o = lvl_t'(i + 1);
        end
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t level_i,
    input  lvl_t mask_i,
    input  logic sample_i,
    input  logic ack_i,
    output logic take_o,
    output logic busy_o,
    output lvl_t lvl_o
);
    acc_st_t s_d, s_q;
    logic    is_nmi, wins, fire;

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;
        is_nmi   = (level_i == NMI_LVL);
        wins     = is_nmi ? s_q.armed : (level_i > mask_i);
        fire     = sample_i && !s_q.busy && wins;
        if (fire) begin
            s_d.take = 1'b1;
            s_d.busy = 1'b1;
            s_d.lvl  = level_i;
        end else if (ack_i && s_q.busy) begin
            s_d.busy = 1'b0;
        end
        if (fire && is_nmi) begin
            s_d.armed = 1'b0;
        end else if (!is_nmi) begin
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{take: 1'b0, busy: 1'b0, armed: 1'b1, lvl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign take_o = s_q.take;
    assign busy_o = s_q.busy;
    assign lvl_o  = s_q.lvl;

    AST_NO_DOUBLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |=> !s_q.take); // R6
    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |-> (s_q.lvl == NMI_LVL || s_q.lvl > $past(mask_i))); // R2
    AST_NO_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |-> (s_q.lvl != '0)); // R3
endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  lvl_t              lvl_i,
    input  logic              ack_i,
    input  logic              ext_i,
    input  logic              none_i,
    input  vec_t              ext_vec_i,
    output logic              valid_o,
    output vec_t              num_o,
    output logic [ADDR_W-1:0] addr_o
);
    vec_st_t v_d, v_q;

    always_comb begin
        v_d       = v_q;
        v_d.valid = 1'b0;
        if (ack_i && busy_i) begin
            v_d.valid = 1'b1;
            if (none_i)     v_d.num = SPUR_VEC;
            else if (ext_i) v_d.num = ext_vec_i;
            else            v_d.num = auto_vec(lvl_i);
            v_d.addr = {v_d.num, 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign valid_o = v_q.valid;
    assign num_o   = v_q.num;
    assign addr_o  = v_q.addr;

    AST_ADDR_TIMES_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.valid |-> (v_q.addr == {v_q.num, 2'b00})); // R7
    AST_SPURIOUS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.valid && $past(none_i)) |-> (v_q.num == SPUR_VEC)); // R9
    AST_EXTERNAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.valid && $past(ext_i) && !$past(none_i)) |-> (v_q.num == $past(ext_vec_i))); // R8
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int N_LINES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic [2:0]         irq_code,
    input  logic [2:0]         cur_mask,
    input  logic               sample_en,
    input  logic               ack_done,
    input  logic               ack_ext,
    input  logic               ack_none,
    input  logic [7:0]         ext_vector,
    output logic               take,
    output logic [2:0]         new_mask,
    output logic               force_super,
    output logic               vec_valid,
    output logic [7:0]         vec_num,
    output logic [9:0]         vec_addr
);
    lvl_t line_lvl, eff_lvl, acc_lvl;
    logic busy;

    irq_line_enc #(.N_LINES(N_LINES)) u_enc (
        .lines_i (irq_lines),
        .level_o (line_lvl)
    );

    assign eff_lvl = (irq_code > line_lvl) ? irq_code : line_lvl;

    irq_accept u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (eff_lvl),
        .mask_i   (cur_mask),
        .sample_i (sample_en),
        .ack_i    (ack_done),
        .take_o   (take),
        .busy_o   (busy),
        .lvl_o    (acc_lvl)
    );

    irq_vector u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy),
        .lvl_i     (acc_lvl),
        .ack_i     (ack_done),
        .ext_i     (ack_ext),
        .none_i    (ack_none),
        .ext_vec_i (ext_vector),
        .valid_o   (vec_valid),
        .num_o     (vec_num),
        .addr_o    (vec_addr)
    );

    assign new_mask    = acc_lvl;
    assign force_super = take;
endmodule

// File: tb/tb_irq_level_ctrl.sv
`timescale 1ns/1ps
module tb_irq_level_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] irq_lines;
    logic [2:0] irq_code, cur_mask;
    logic       sample_en, ack_done, ack_ext, ack_none;
    logic [7:0] ext_vector;
    logic       take, force_super, vec_valid;
    logic [2:0] new_mask;
    logic [7:0] vec_num;
    logic [9:0] vec_addr;

    int checks = 0;
    int errors = 0;

    logic       m_busy, m_armed, m_take, m_vvalid;
    logic [2:0] m_lvl;
    logic [7:0] m_vnum;

    irq_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_code(irq_code),
        .cur_mask(cur_mask), .sample_en(sample_en), .ack_done(ack_done),
        .ack_ext(ack_ext), .ack_none(ack_none), .ext_vector(ext_vector),
        .take(take), .new_mask(new_mask), .force_super(force_super),
        .vec_valid(vec_valid), .vec_num(vec_num), .vec_addr(vec_addr)
    );

    always #2 clk = ~clk;

    function automatic logic [2:0] enc_lines(logic [6:0] l);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 7; i++) if (l[i]) r = 3'(i + 1);
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic st, logic [2:0] code, logic [6:0] lines,
                        logic [2:0] mask, logic ack, logic ext, logic none, logic [7:0] vec);
        logic [2:0] eff;
        logic fire, ackf;
        sample_en = st; irq_code = code; irq_lines = lines; cur_mask = mask;
        ack_done = ack; ack_ext = ext; ack_none = none; ext_vector = vec;
        @(posedge clk);
        eff  = (code > enc_lines(lines)) ? code : enc_lines(lines);
        fire = st && !m_busy && ((eff == 3'd7) ? m_armed : (eff > mask));
        ackf = ack && m_busy;
        m_take   = fire;
        m_vvalid = ackf;
        if (ackf) m_vnum = none ? 8'd24 : (ext ? vec : 8'd24 + 8'(m_lvl));
        if (fire) begin m_lvl = eff; m_busy = 1'b1; end
        else if (ackf) m_busy = 1'b0;
        if (fire && eff == 3'd7) m_armed = 1'b0;
        else if (eff != 3'd7) m_armed = 1'b1;
        @(negedge clk);
        check(tag, "take", int'(take), int'(m_take));
        check(tag, "force_super", int'(force_super), int'(m_take));
        check(tag, "new_mask", int'(new_mask), int'(m_lvl));
        check(tag, "vec_valid", int'(vec_valid), int'(m_vvalid));
        if (m_vvalid) begin
            check(tag, "vec_num", int'(vec_num), int'(m_vnum));
            check(tag, "vec_addr", int'(vec_addr), int'(m_vnum) * 4);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0; sample_en = 0; irq_code = 0; irq_lines = 0; cur_mask = 0;
        ack_done = 0; ack_ext = 0; ack_none = 0; ext_vector = 0;
        m_busy = 0; m_armed = 1; m_take = 0; m_vvalid = 0; m_lvl = 0; m_vnum = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "take", int'(take), 0);
        check("R1", "force_super", int'(force_super), 0);
        check("R1", "vec_valid", int'(vec_valid), 0);
        check("R1", "new_mask", int'(new_mask), 0);

        // R2 R5 accept above mask, R7 autovector
        step("R2", 1, 3, 0, 2, 0, 0, 0, 0);
        check("R5", "new_mask_level3", int'(new_mask), 3);
        step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
        check("R7", "autovec27", int'(vec_num), 27);
        // R2 equal to mask is refused, R3 level zero
        step("R2", 1, 2, 0, 2, 0, 0, 0, 0);
        step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
        // R6 busy ignores sample, R8 external vector
        step("R2", 1, 3, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 5, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 6, 0, 1, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 1, 0, 8'h40);
        check("R8", "ext_addr256", int'(vec_addr), 256);
        // R9 spurious wins over external
        step("R2", 1, 4, 0, 1, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 1, 1, 8'h99);
        check("R9", "spur_addr96", int'(vec_addr), 96);
        // R11 stray acknowledge
        step("R11", 0, 0, 0, 0, 1, 0, 0, 0);
        check("R11", "no_vec", int'(vec_valid), 0);
        // R4 level 7 ignores mask, fires once, re-arms after dip
        step("R4", 1, 7, 0, 7, 0, 0, 0, 0);
        check("R4", "nmi_take", int'(take), 1);
        step("R4", 0, 7, 0, 7, 1, 0, 0, 0);
        step("R4", 1, 7, 0, 7, 0, 0, 0, 0);
        step("R4", 1, 7, 0, 0, 0, 0, 0, 0);
        check("R4", "nmi_held_no_take", int'(take), 0);
        step("R4", 0, 6, 0, 7, 0, 0, 0, 0);
        step("R4", 1, 7, 0, 7, 0, 0, 0, 0);
        check("R4", "nmi_rearm_take", int'(take), 1);
        step("R4", 0, 0, 0, 7, 1, 0, 0, 0);
        // R10 encoder highest line wins, combined with code
        step("R10", 1, 0, 7'b0010010, 0, 0, 0, 0, 0);
        check("R10", "enc_level5", int'(new_mask), 5);
        step("R10", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R10", 1, 2, 7'b0000101, 2, 0, 0, 0, 0);
        check("R10", "enc_max3", int'(new_mask), 3);
        step("R10", 0, 0, 0, 0, 1, 0, 0, 0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] ln = ($urandom_range(3) == 0) ? 7'($urandom) : 7'd0;
            step("R2", 1'($urandom_range(1)), 3'($urandom), ln, 3'($urandom),
                 $urandom_range(9) < 3, $urandom_range(9) < 3,
                 $urandom_range(19) < 3, 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule